// File: doc/BRIEF.md
# EEPROM Write Burst Address Sequencer

This block sits between the serial front end of an EEPROM and its storage array. For each write transaction it takes the start address and then the stream of data bytes. For each byte it accepts, it issues one write strobe carrying the array address and the byte. It supports two burst styles. In page style the counter stays inside one aligned page. In linear style the counter steps straight through the address space, crossing page edges. A single-byte write is a burst that ends after one byte.

A transaction opens with a one-cycle `start_i`. At that point the block captures the start address, the style select and the verdict of an external protection checker. The verdict comes from the start address alone. A linear burst that begins just below a protected region can therefore write up to seven bytes into it. When `stop_i` closes a burst that wrote at least one byte, the block pulses `prog_start_o` to launch the self-timed programming cycle. It then holds `busy_o` high for a fixed number of cycles and refuses new transactions during that time.

Top module: `eeprom_wr_sequencer`

## Requirements
- R1: While `rst` is high, and in the cycle after it, `wr_en_o`, `prog_start_o` and `busy_o` are 0, and `wr_addr_o` and `wr_data_o` are 0.
- R2: When a burst is open, a `data_valid_i` byte that is accepted drives `wr_en_o` high for exactly the next cycle. In that cycle `wr_addr_o` is the current burst address and `wr_data_o` is the byte. `wr_addr_o` and `wr_data_o` hold their values when no byte is accepted.
- R3: In page style (`multi_i` = 0 at start), each accepted byte advances only the low PAGE_BITS (default 4) address bits, wrapping from all-ones to 0. The upper bits keep their start value for the whole burst.
- R4: In linear style (`multi_i` = 1 at start), each accepted byte advances the whole AW-bit address by one. The address crosses page edges and wraps from all-ones to 0.
- R5: A burst accepts at most MULTI_MAX (8) bytes in linear style and PAGE_MAX (16) bytes in page style. Any further byte produces no strobe.
- R6: If `protect_i` is 1 in the start cycle, no byte of that burst produces a strobe. The value of `protect_i` after the start cycle has no effect on the burst.
- R7: A `stop_i` that closes a burst with at least one strobe gives a one-cycle `prog_start_o` in the next cycle. `busy_o` is high for exactly PROG_CYCLES cycles starting in that same cycle.
- R8: A `stop_i` that closes a burst with no strobe (protected, or with no data) gives no `prog_start_o` and no `busy_o`.
- R9: `start_i` is ignored while `busy_o` is high or while a burst is open. `data_valid_i` and `stop_i` are ignored when no burst is open.
- R10: A `data_valid_i` byte presented in the same cycle as `stop_i` is not accepted.
- R11: The burst style is fixed by `multi_i` in the start cycle. Later changes of `multi_i` have no effect on the burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Opens a write transaction (one cycle) |
| start_addr_i | input | AW | First array address of the burst |
| multi_i | input | 1 | Burst style at start: 1 linear, 0 page |
| protect_i | input | 1 | Protection verdict for the start address |
| data_valid_i | input | 1 | A data byte is presented this cycle |
| data_i | input | DW | Data byte |
| stop_i | input | 1 | Closes the transaction |
| wr_en_o | output | 1 | Array write strobe |
| wr_addr_o | output | AW | Array address of the strobed byte |
| wr_data_o | output | DW | Strobed data byte |
| prog_start_o | output | 1 | One-cycle launch of the program cycle |
| busy_o | output | 1 | Program cycle in progress |

## Verification
The bench aims at the page wrap from 0x3FF to 0x3F0. A design that carried into the upper bits there would write outside the page. It also drives a linear burst across a page edge and another across the top of memory. A design that wrapped either one inside the page would overwrite the start of the page. Bytes past the limits of 8 and 16 are sent to catch an off-by-one count. So is a byte that arrives together with stop.

A protected start is sent with the verdict dropped in mid-burst. A design that re-sampled it would strobe the later bytes. Another run changes the style select in mid-burst. Starts are raised during busy and inside an open burst; a design that honoured them would re-aim the address or write during the program cycle.

// File: rtl/wrseq_pkg.sv
package wrseq_pkg;
  typedef enum logic {
    S_IDLE  = 1'b0,
    S_BURST = 1'b1
  } seq_state_e;

  function automatic int max_of(int a, int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/wrseq_addr_step.sv
module wrseq_addr_step #(
  parameter int AW        = 11,
  parameter int PAGE_BITS = 4
) (
  input  logic [AW-1:0] cur_i,
  input  logic          linear_i,
  output logic [AW-1:0] nxt_o
);
  logic [AW-1:0] lin_next;
  assign lin_next = cur_i + 1'b1;

  generate
    if (PAGE_BITS >= AW) begin : g_whole
      assign nxt_o = lin_next;
    end else begin : g_split
      logic [PAGE_BITS-1:0] low_next;
      assign low_next = cur_i[PAGE_BITS-1:0] + 1'b1;
      assign nxt_o = linear_i ? lin_next : {cur_i[AW-1:PAGE_BITS], low_next};
    end
  endgenerate
endmodule

// File: rtl/wrseq_prog_timer.sv
module wrseq_prog_timer #(
  parameter int PROG_CYCLES = 1000
) (
  input  logic clk,
  input  logic rst,
  input  logic load_i,
  output logic busy_o
);
  localparam int TW = $clog2(PROG_CYCLES + 1);

  logic [TW-1:0] left_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      left_q <= '0;
    end else if (load_i) begin
      left_q <= TW'(PROG_CYCLES);
    end else if (left_q != '0) begin
      left_q <= left_q - 1'b1;
    end
  end

  assign busy_o = (left_q != '0);

  assert_busy_after_load_R7: assert property (@(posedge clk) disable iff (rst)
    load_i |=> busy_o);
endmodule

// File: rtl/wrseq_burst_ctrl.sv
module wrseq_burst_ctrl
  import wrseq_pkg::*;
#(
  parameter int AW        = 11,
  parameter int DW        = 8,
  parameter int PAGE_BITS = 4,
  parameter int MULTI_MAX = 8,
  parameter int PAGE_MAX  = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  input  logic [AW-1:0] start_addr_i,
  input  logic          multi_i,
  input  logic          protect_i,
  input  logic          data_valid_i,
  input  logic [DW-1:0] data_i,
  input  logic          stop_i,
  input  logic          busy_i,
  output logic          wr_en_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [DW-1:0] wr_data_o,
  output logic          prog_start_o,
  output logic          fire_o
);
  localparam int MAXB = max_of(MULTI_MAX, PAGE_MAX);
  localparam int CW   = $clog2(MAXB + 1);

  seq_state_e    state_q;
  logic [AW-1:0] addr_q;
  logic [AW-1:0] addr_nxt;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] lim_w;
  logic          prot_q;
  logic          mode_q;
  logic          written_q;
  logic          take;

  wrseq_addr_step #(.AW(AW), .PAGE_BITS(PAGE_BITS)) u_step (
    .cur_i    (addr_q),
    .linear_i (mode_q),
    .nxt_o    (addr_nxt)
  );

  assign lim_w  = mode_q ? CW'(MULTI_MAX) : CW'(PAGE_MAX);
  assign take   = (state_q == S_BURST) && !stop_i && data_valid_i && !prot_q && (cnt_q < lim_w);
  assign fire_o = (state_q == S_BURST) && stop_i && written_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= S_IDLE;
      addr_q       <= '0;
      cnt_q        <= '0;
      prot_q       <= 1'b0;
      mode_q       <= 1'b0;
      written_q    <= 1'b0;
      wr_en_o      <= 1'b0;
      wr_addr_o    <= '0;
      wr_data_o    <= '0;
      prog_start_o <= 1'b0;
    end else begin
      wr_en_o      <= 1'b0;
      prog_start_o <= 1'b0;
      case (state_q)
        S_IDLE: begin
          if (start_i && !busy_i) begin
            state_q   <= S_BURST;
            addr_q    <= start_addr_i;
            cnt_q     <= '0;
            prot_q    <= protect_i;
            mode_q    <= multi_i;
            written_q <= 1'b0;
          end
        end
        S_BURST: begin
          if (stop_i) begin
            state_q      <= S_IDLE;
            prog_start_o <= written_q;
          end else if (take) begin
            wr_en_o   <= 1'b1;
            wr_addr_o <= addr_q;
            wr_data_o <= data_i;
            addr_q    <= addr_nxt;
            cnt_q     <= cnt_q + 1'b1;
            written_q <= 1'b1;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assert_no_write_protected_R6: assert property (@(posedge clk) disable iff (rst)
    wr_en_o |-> !prot_q);

  assert_count_in_limit_R5: assert property (@(posedge clk) disable iff (rst)
    wr_en_o |-> (cnt_q <= lim_w) && (cnt_q != '0));

  generate
    if (PAGE_BITS < AW) begin : g_page_chk
      assert_page_upper_fixed_R3: assert property (@(posedge clk) disable iff (rst)
        (!mode_q && wr_en_o && $past(wr_en_o)) |->
          (wr_addr_o[AW-1:PAGE_BITS] == $past(wr_addr_o[AW-1:PAGE_BITS])));
    end
  endgenerate

  assert_linear_step_R4: assert property (@(posedge clk) disable iff (rst)
    (mode_q && wr_en_o && $past(wr_en_o)) |-> (wr_addr_o == AW'($past(wr_addr_o) + 1'b1)));
endmodule

// File: rtl/eeprom_wr_sequencer.sv
module eeprom_wr_sequencer #(
  parameter int AW          = 11,
  parameter int DW          = 8,
  parameter int PAGE_BITS   = 4,
  parameter int MULTI_MAX   = 8,
  parameter int PAGE_MAX    = 16,
  parameter int PROG_CYCLES = 1000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  input  logic [AW-1:0] start_addr_i,
  input  logic          multi_i,
  input  logic          protect_i,
  input  logic          data_valid_i,
  input  logic [DW-1:0] data_i,
  input  logic          stop_i,
  output logic          wr_en_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [DW-1:0] wr_data_o,
  output logic          prog_start_o,
  output logic          busy_o
);
  logic fire;

  wrseq_burst_ctrl #(
    .AW(AW), .DW(DW), .PAGE_BITS(PAGE_BITS),
    .MULTI_MAX(MULTI_MAX), .PAGE_MAX(PAGE_MAX)
  ) u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .start_i      (start_i),
    .start_addr_i (start_addr_i),
    .multi_i      (multi_i),
    .protect_i    (protect_i),
    .data_valid_i (data_valid_i),
    .data_i       (data_i),
    .stop_i       (stop_i),
    .busy_i       (busy_o),
    .wr_en_o      (wr_en_o),
    .wr_addr_o    (wr_addr_o),
    .wr_data_o    (wr_data_o),
    .prog_start_o (prog_start_o),
    .fire_o       (fire)
  );

  wrseq_prog_timer #(.PROG_CYCLES(PROG_CYCLES)) u_timer (
    .clk    (clk),
    .rst    (rst),
    .load_i (fire),
    .busy_o (busy_o)
  );

  assert_prog_single_R7: assert property (@(posedge clk) disable iff (rst)
    prog_start_o |=> !prog_start_o);

  assert_prog_with_busy_R7: assert property (@(posedge clk) disable iff (rst)
    prog_start_o |-> busy_o);

  assert_quiet_while_busy_R9: assert property (@(posedge clk) disable iff (rst)
    busy_o |-> !wr_en_o);
endmodule

// File: tb/eeprom_wr_sequencer_tb_top.sv
`timescale 1ns/1ps
module eeprom_wr_sequencer_tb_top;
  localparam int AW = 11;
  localparam int DW = 8;
  localparam int PC = 24;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start_i = 1'b0;
  logic [AW-1:0] start_addr_i = '0;
  logic          multi_i = 1'b0;
  logic          protect_i = 1'b0;
  logic          data_valid_i = 1'b0;
  logic [DW-1:0] data_i = '0;
  logic          stop_i = 1'b0;
  logic          wr_en_o;
  logic [AW-1:0] wr_addr_o;
  logic [DW-1:0] wr_data_o;
  logic          prog_start_o;
  logic          busy_o;

  always #2.5 clk = ~clk;

  eeprom_wr_sequencer #(.AW(AW), .DW(DW), .PAGE_BITS(4), .MULTI_MAX(8),
                        .PAGE_MAX(16), .PROG_CYCLES(PC)) dut_i (
    .clk(clk), .rst(rst), .start_i(start_i), .start_addr_i(start_addr_i),
    .multi_i(multi_i), .protect_i(protect_i), .data_valid_i(data_valid_i),
    .data_i(data_i), .stop_i(stop_i), .wr_en_o(wr_en_o), .wr_addr_o(wr_addr_o),
    .wr_data_o(wr_data_o), .prog_start_o(prog_start_o), .busy_o(busy_o));

  int    n_checks = 0;
  int    n_fail   = 0;
  bit    done     = 0;
  string phase    = "R1";

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // behavioural reference model
  bit        m_open, m_prot, m_mode, m_written;
  int        m_addr, m_cnt, m_busy;
  bit        e_wr, e_prog;
  int        e_addr, e_data;

  always @(posedge clk) begin
    if (rst) begin
      m_open = 0; m_prot = 0; m_mode = 0; m_written = 0;
      m_addr = 0; m_cnt = 0; m_busy = 0;
      e_wr = 0; e_prog = 0; e_addr = 0; e_data = 0;
    end else begin
      bit was_busy;
      bit fire;
      was_busy = (m_busy != 0);
      fire = 0;
      e_wr = 0;
      e_prog = 0;
      if (!m_open) begin
        if (start_i && !was_busy) begin
          m_open = 1; m_addr = int'(start_addr_i); m_cnt = 0;
          m_prot = protect_i; m_mode = multi_i; m_written = 0;
        end
      end else if (stop_i) begin
        m_open = 0;
        if (m_written) begin fire = 1; e_prog = 1; end
      end else if (data_valid_i && !m_prot && m_cnt < (m_mode ? 8 : 16)) begin
        e_wr = 1; e_addr = m_addr; e_data = int'(data_i);
        m_written = 1; m_cnt++;
        if (m_mode) m_addr = (m_addr + 1) % (1 << AW);
        else m_addr = (m_addr & ~15) | ((m_addr + 1) & 15);
      end
      if (fire) m_busy = PC;
      else if (m_busy > 0) m_busy--;
    end
  end

  // observation counters, sampled before the edge updates the outputs
  int wr_seen = 0, prog_seen = 0, busy_seen = 0;
  always @(posedge clk) begin
    if (!rst) begin
      if (wr_en_o) wr_seen++;
      if (prog_start_o) prog_seen++;
      if (busy_o) busy_seen++;
    end
  end

  // every-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk(wr_en_o == e_wr, phase, "wr_en_o", int'(wr_en_o), int'(e_wr));
      chk(int'(wr_addr_o) == e_addr, phase, "wr_addr_o", int'(wr_addr_o), e_addr);
      chk(int'(wr_data_o) == e_data, phase, "wr_data_o", int'(wr_data_o), e_data);
      chk(prog_start_o == e_prog, phase, "prog_start_o", int'(prog_start_o), int'(e_prog));
      chk(busy_o == (m_busy != 0), phase, "busy_o", int'(busy_o), int'(m_busy != 0));
    end
  end

  task automatic tick(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic open_burst(int a, bit m, bit p);
    start_i = 1; start_addr_i = AW'(a); multi_i = m; protect_i = p;
    tick();
    start_i = 0;
  endtask

  task automatic send(int d);
    data_valid_i = 1; data_i = DW'(d);
    tick();
    data_valid_i = 0;
  endtask

  task automatic close_burst();
    stop_i = 1;
    tick();
    stop_i = 0;
  endtask

  task automatic wait_idle();
    tick(2);
    while (busy_o) tick();
    tick(2);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_checks++; n_fail++;
      $display("FAIL watchdog expired actual 1 expected 0");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    int w0, p0, b0;
    repeat (3) @(negedge clk);
    chk(wr_en_o == 0, "R1", "wr_en_o in reset", int'(wr_en_o), 0);
    chk(prog_start_o == 0, "R1", "prog_start_o in reset", int'(prog_start_o), 0);
    chk(busy_o == 0, "R1", "busy_o in reset", int'(busy_o), 0);
    chk(wr_addr_o == 0 && wr_data_o == 0, "R1", "addr/data in reset",
        int'(wr_addr_o) + int'(wr_data_o), 0);
    rst = 0;
    tick(2);

    // single byte write, program launch and busy length
    phase = "R2";
    w0 = wr_seen; p0 = prog_seen;
    open_burst('h123, 0, 0);
    send('hA5);
    chk(wr_en_o && wr_addr_o == 'h123 && wr_data_o == 'hA5, "R2", "single byte strobe",
        int'(wr_addr_o), 'h123);
    tick();
    phase = "R7";
    b0 = busy_seen;
    close_burst();
    chk(prog_start_o && busy_o, "R7", "prog and busy after stop",
        int'(prog_start_o) + int'(busy_o), 2);
    wait_idle();
    chk(busy_seen - b0 == PC, "R7", "busy cycles", busy_seen - b0, PC);
    chk(prog_seen - p0 == 1, "R7", "prog pulses", prog_seen - p0, 1);
    chk(wr_seen - w0 == 1, "R2", "strobes", wr_seen - w0, 1);

    // page burst wrapping at the page edge, then overflow
    phase = "R3";
    w0 = wr_seen;
    open_burst('h3FA, 0, 0);
    for (int i = 0; i < 16; i++) begin
      send('h10 + i);
      if (i == 6) chk(wr_addr_o == 'h3F0, "R3", "page wrap address", int'(wr_addr_o), 'h3F0);
      if (i % 5 == 4) tick();
    end
    phase = "R5";
    send('hEE);
    send('hEF);
    chk(wr_en_o == 0, "R5", "byte 17 in page style", int'(wr_en_o), 0);
    close_burst();
    wait_idle();
    chk(wr_seen - w0 == 16, "R5", "page strobes", wr_seen - w0, 16);

    // linear burst crossing a page edge, start inside burst ignored, overflow
    phase = "R4";
    w0 = wr_seen;
    open_burst('h3FC, 1, 0);
    send(1); send(2); send(3); send(4);
    chk(wr_addr_o == 'h3FF, "R4", "before edge", int'(wr_addr_o), 'h3FF);
    phase = "R9";
    open_burst('h055, 0, 1);
    phase = "R4";
    send(5);
    chk(wr_addr_o == 'h400, "R4", "across page edge", int'(wr_addr_o), 'h400);
    send(6); send(7); send(8);
    phase = "R5";
    send(9);
    chk(wr_en_o == 0, "R5", "byte 9 in linear style", int'(wr_en_o), 0);
    send(10);
    close_burst();
    wait_idle();
    chk(wr_seen - w0 == 8, "R5", "linear strobes", wr_seen - w0, 8);

    // linear burst wrapping at top of memory
    phase = "R4";
    open_burst('h7FE, 1, 0);
    send('hA0); send('hA1); send('hA2);
    chk(wr_addr_o == 'h000, "R4", "top wrap", int'(wr_addr_o), 0);
    close_burst();
    wait_idle();

    // protected start, verdict dropped later
    phase = "R6";
    w0 = wr_seen; p0 = prog_seen; b0 = busy_seen;
    open_burst('h700, 1, 1);
    protect_i = 0;
    send(1); send(2); send(3);
    phase = "R8";
    close_burst();
    tick(3);
    chk(wr_seen - w0 == 0, "R6", "strobes in protected burst", wr_seen - w0, 0);
    chk(prog_seen - p0 == 0 && busy_seen - b0 == 0, "R8", "program after protected burst",
        prog_seen - p0 + busy_seen - b0, 0);

    // empty burst, stray data and stop while idle
    p0 = prog_seen;
    open_burst('h010, 0, 0);
    tick(2);
    close_burst();
    phase = "R9";
    send('h33);
    close_burst();
    tick(3);
    chk(prog_seen - p0 == 0 && busy_o == 0, "R8", "empty burst program",
        prog_seen - p0 + int'(busy_o), 0);

    // start during busy ignored
    phase = "R9";
    open_burst('h020, 0, 0);
    send('h44);
    close_burst();
    w0 = wr_seen;
    tick(2);
    open_burst('h055, 1, 0);
    send('h66); send('h67);
    wait_idle();
    send('h68);
    tick(2);
    chk(wr_seen - w0 == 0, "R9", "strobes from start during busy", wr_seen - w0, 0);

    // data together with stop
    phase = "R10";
    w0 = wr_seen;
    open_burst('h200, 0, 0);
    send('h01);
    data_valid_i = 1; data_i = 'h02; stop_i = 1;
    tick();
    data_valid_i = 0; stop_i = 0;
    chk(wr_en_o == 0, "R10", "byte with stop", int'(wr_en_o), 0);
    wait_idle();
    chk(wr_seen - w0 == 1, "R10", "strobes", wr_seen - w0, 1);

    // style select changed mid-burst
    phase = "R11";
    open_burst('h1FE, 0, 0);
    multi_i = 1;
    send('h90); send('h91); send('h92);
    chk(wr_addr_o == 'h1F0, "R11", "page wrap kept", int'(wr_addr_o), 'h1F0);
    close_burst();
    wait_idle();

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule